// File: doc/BRIEF.md
# Serial Timebase Load Port

This block takes an 8-bit duration setting over a three-wire serial link and turns it into the 16-bit phase-length value used by a conversion timer. The host holds an active-low strobe low, presents bits on a data line most significant bit first, and marks each bit with a rising edge on a shift clock. When the strobe goes high again, the assembled byte becomes the upper byte of the output value. The lower byte is always all ones.

A quicker form of loading is also available. The host pulses the strobe low and sends no shift clocks. The level of the data line when the strobe rises then picks one of two default lengths. All three serial inputs are synchronised into the system clock domain, and their edges are detected there, so the whole block runs on one clock. A flag stays low from reset until the first value has been committed. The downstream sequencer must not start integration cycles while this flag is low. The value can be loaded again at any time.

Top module: `tbase_load_port`

## Requirements
- R1: With the strobe low, each rising edge of the shift clock shifts the data line into the byte register, most significant bit first. After exactly eight edges, a rising strobe makes the output's upper byte, bits 15..8, equal to the eight bits in the order they were sent.
- R2: Shift-clock edges that arrive while the strobe is high shift nothing and commit nothing. The output value and the commit pulse are left unchanged.
- R3: The output value changes only when the strobe rises. Each rise produces exactly one single-cycle commit pulse, in the same cycle as the value update.
- R4: Bits 7..0 of the output are always 0xFF. After reset the output is 0xFFFF.
- R5: A strobe rise with zero shift-clock edges since the strobe fell is a shortcut load. The upper byte becomes 0xFF if the data line is high at the rise, giving a count of 65536, and 0x7F if it is low, giving a count of 32768.
- R6: The byte register is cleared when the strobe falls. If the number of edges at the rise is neither zero nor eight, the upper byte takes the last eight bits shifted, with zeros in any positions that received no bit. A sticky short-load flag is then set and cleared only by reset.
- R7: The configured flag is low from reset until the first commit. It then stays high until the next reset.
- R8: A later load fully replaces an earlier committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Shift clock, rising edge active, asynchronous |
| load_n | input | 1 | Active-low load strobe, asynchronous |
| phase_len | output | 16 | Committed phase-length value |
| commit | output | 1 | One-cycle pulse when a value is committed |
| configured | output | 1 | High once any value has been committed |
| short_load | output | 1 | Sticky flag for a load with an irregular bit count |

## Verification
A wrong edge count or a wrong byte-register state stays hidden while the strobe is low. It shows at the ports only a few cycles after the strobe rises, through the synchroniser and the commit register. A shortcut load might then be taken as a real load, or a bit might be lost. Either mistake shows up as a wrong upper byte or a wrong short-load flag, and the bench reads both after every strobe rise. A broken commit path shows up as a missing or repeated commit pulse, or as the output changing while the strobe is idle.

// File: rtl/tbase_pkg.sv
// Shared constants for the serial timebase load port.
// Assumes an 8-bit setting placed above a fixed all-ones low byte.
package tbase_pkg;
    parameter int BYTE_W = 8;
    parameter int VAL_W = 2 * BYTE_W;
    parameter logic [BYTE_W-1:0] LOW_FILL = 8'hFF;
    parameter logic [BYTE_W-1:0] QUICK_HI = 8'hFF;
    parameter logic [BYTE_W-1:0] QUICK_LO = 8'h7F;
endpackage

// File: rtl/tbase_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent. RST_VAL gives each stage its reset level.
module tbase_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else if (s == 0) pipe[s] <= d;
                else pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/tbase_shifter.sv
// Byte shift register and saturating edge counter.
// Clears on `clear` (the strobe's falling edge). Shifts MSB first on `shift`.
module tbase_shifter
    import tbase_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_q,
    output logic [CNT_W-1:0]  edges
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Assemble the incoming bits, newest in the least significant position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) byte_q <= '0;
        else if (shift) byte_q <= {byte_q[BYTE_W-2:0], bit_in};
    end

    // Count the shift edges since the strobe fell, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) edges <= '0;
        else if (shift && edges != CNT_MAX) edges <= edges + 1'b1;
    end
endmodule

// File: rtl/tbase_commit.sv
// Commit logic: on the strobe's rising edge, picks the shifted byte or a
// shortcut default and registers it. Also keeps the configured and
// short-load flags. Assumes `rise` lasts a single cycle.
module tbase_commit
    import tbase_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              bit_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [CNT_W-1:0]  edges,
    output logic [BYTE_W-1:0] upper,
    output logic              pulse,
    output logic              cfg,
    output logic              short_q
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] pick;
    logic              odd_count;

    // Choose the byte to commit, based on how many edges were seen.
    always_comb begin
        if (edges == '0) pick = bit_in ? QUICK_HI : QUICK_LO;
        else pick = byte_in;
        odd_count = (edges != '0) && (edges != FULL);
    end

    // Register the committed byte and the one-cycle commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper <= QUICK_HI;
            pulse <= 1'b0;
        end else begin
            pulse <= rise;
            if (rise) upper <= pick;
        end
    end

    // Sticky flags: configured after the first commit, and a short load seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= 1'b0;
            short_q <= 1'b0;
        end else if (rise) begin
            cfg <= 1'b1;
            if (odd_count) short_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tbase_load_port.sv
// Top of the serial timebase load port. Brings the three serial inputs
// into the clk domain, finds the strobe and shift-clock edges, and drives
// the shifter and commit stages. Assumes every input level is held for at
// least SYNC_STAGES+1 clk cycles.
module tbase_load_port
    import tbase_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    input  logic             ser_clk,
    input  logic             load_n,
    output logic [VAL_W-1:0] phase_len,
    output logic             commit,
    output logic             configured,
    output logic             short_load
);
    localparam int CNT_W = $clog2(BYTE_W) + 2;

    logic [2:0]        raw_in, sync_out;
    logic              data_s, sclk_s, load_s;
    logic              sclk_d, load_d;
    logic              sclk_rise, load_rise, load_fall;
    logic [BYTE_W-1:0] byte_q, upper;
    logic [CNT_W-1:0]  edges;

    assign raw_in = {load_n, ser_clk, ser_data};

    tbase_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
    );

    assign {load_s, sclk_s, data_s} = sync_out;

    // Previous synchronised levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            load_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            load_d <= load_s;
        end
    end

    assign sclk_rise = sclk_s && !sclk_d && !load_s;
    assign load_rise = load_s && !load_d;
    assign load_fall = !load_s && load_d;

    tbase_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(load_fall), .shift(sclk_rise),
        .bit_in(data_s), .byte_q(byte_q), .edges(edges)
    );

    tbase_commit #(.CNT_W(CNT_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .rise(load_rise), .bit_in(data_s),
        .byte_in(byte_q), .edges(edges), .upper(upper), .pulse(commit),
        .cfg(configured), .short_q(short_load)
    );

    assign phase_len = {upper, LOW_FILL};
endmodule

// File: rtl/tbase_load_port_chk.sv
// Checker for tbase_load_port, attached to it with bind.
module tbase_load_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] phase_len,
    input logic        commit,
    input logic        configured,
    input logic        short_load
);
    AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> phase_len == $past(phase_len)); // R3
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R3
    AST_CFG_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured) |-> commit); // R7
    AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> configured); // R7
    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        short_load |=> short_load); // R6
    AST_SHORT_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_load) |-> commit); // R6
endmodule

bind tbase_load_port tbase_load_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .phase_len(phase_len), .commit(commit),
    .configured(configured), .short_load(short_load)
);

// File: tb/test_tbase_load_port.sv
module test_tbase_load_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_clk = 1'b0;
    logic        load_n = 1'b1;
    logic [15:0] phase_len;
    logic        commit, configured, short_load;
    int          n_chk = 0, n_fail = 0, n_commit = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    tbase_load_port i_tbase_load_port (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .load_n(load_n), .phase_len(phase_len), .commit(commit),
        .configured(configured), .short_load(short_load)
    );

    always @(negedge clk) if (rst_n && commit) n_commit++;

    // Vector: {bit count[3:0], bits[11:0] sent from bit 11 down,
    //          data level at strobe rise, expected upper byte[7:0]}
    localparam int NV = 6;
    localparam logic [24:0] VEC [NV] = '{
        {4'd8, 12'hA50, 1'b0, 8'hA5},
        {4'd8, 12'h3C0, 1'b1, 8'h3C},
        {4'd0, 12'h000, 1'b1, 8'hFF},
        {4'd0, 12'h000, 1'b0, 8'h7F},
        {4'd8, 12'h000, 1'b1, 8'h00},
        {4'd8, 12'hFF0, 1'b0, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input int cnt, input logic [11:0] bits, input logic lvl);
        load_n = 1'b0;
        idle(4);
        for (int i = 0; i < cnt; i++) begin
            ser_data = bits[11-i];
            idle(3);
            ser_clk = 1'b1;
            idle(3);
            ser_clk = 1'b0;
            idle(3);
        end
        ser_data = lvl;
        idle(4);
        load_n = 1'b1;
        idle(6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int prev;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R4 reset value", phase_len, 16'hFFFF);
        check("R7 not configured after reset", configured, 0);
        check("R6 short flag clear after reset", short_load, 0);

        // R2: shift clocks with the strobe high are ignored
        prev = n_commit;
        for (int i = 0; i < 4; i++) begin
            ser_clk = 1'b1; idle(3); ser_clk = 1'b0; idle(3);
        end
        check("R2 no commit while strobe high", n_commit - prev, 0);
        check("R2 value unchanged", phase_len, 16'hFFFF);
        check("R7 still unconfigured", configured, 0);

        for (int v = 0; v < NV; v++) begin
            prev = n_commit;
            do_load(int'(VEC[v][24:21]), VEC[v][20:9], VEC[v][8]);
            check("R1/R5/R8 upper byte", phase_len[15:8], VEC[v][7:0]);
            check("R4 low byte", phase_len[7:0], 8'hFF);
            check("R3 one commit per load", n_commit - prev, 1);
            check("R7 configured", configured, 1);
            check("R6 no short flag", short_load, 0);
        end

        // R2: a byte sent with the strobe high does not alter the loaded byte
        for (int i = 0; i < 8; i++) begin
            ser_data = 1'b0; idle(2); ser_clk = 1'b1; idle(3); ser_clk = 1'b0; idle(2);
        end
        idle(4);
        check("R2 value kept after idle clocks", phase_len, 16'hFFFF);

        // R6: three bits 1,0,1 -> 0x05, short flag set
        do_load(3, 12'hA00, 1'b0);
        check("R6 partial byte", phase_len[15:8], 8'h05);
        check("R6 short flag set", short_load, 1);

        // R6: ten bits 1100101011 -> last eight 0x2B, flag stays set
        do_load(10, 12'hCAC, 1'b1);
        check("R6 long load keeps low eight bits", phase_len[15:8], 8'h2B);
        check("R6 short flag sticky", short_load, 1);

        // R8: a regular load after that still replaces the value
        do_load(8, 12'h5A0, 1'b0);
        check("R8 rewrite", phase_len[15:8], 8'h5A);

        // R7/R4: reset clears the flags and restores the value
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        check("R7 unconfigured after second reset", configured, 0);
        check("R6 short flag cleared by reset", short_load, 0);
        check("R4 value after second reset", phase_len, 16'hFFFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule